// File: doc/BRIEF.md
# Rotating Three-Character Word Display

This block shows a three-letter word on three 7-segment digits and turns the word around the digits in a circle. Six switch bits hold three 2-bit character codes. Bits 5..4 give the first letter, bits 3..2 the second and bits 1..0 the third. Two more switch bits, 9..8, choose how far the word is turned. The character set has four members: d, E, one digit character chosen by a parameter (0, 1 or 2), and a blank.

Each digit has its own two-bit-wide 3-to-1 multiplexer. The three multiplexers see the same three codes, each in a cyclically shifted order, so a single select value turns the whole word at once. After each multiplexer comes a decoder that turns the code into an active-low segment pattern. The block also copies all ten switch bits to ten LED outputs. The block is purely combinational and has no clock, no reset and no state.

Top module: `rotword_display`

## Requirements
- R1: Each bit of `ledr` equals the bit of `sw` at the same position, for every input value.
- R2: Code 00 shows the letter d. The pattern is 7'h21, active low, with bit 0 = segment a through bit 6 = segment g.
- R3: Code 01 shows the letter E, pattern 7'h06.
- R4: Code 10 shows the digit character. With the default digit 1 the pattern is 7'h79. Digit 0 gives 7'h40 and digit 2 gives 7'h24.
- R5: Code 11 is a blank, pattern 7'h7F, so all segments are off.
- R6: With `sw[9:8]` = 00, `segLeft` shows `sw[5:4]`, `segMid` shows `sw[3:2]` and `segRight` shows `sw[1:0]`.
- R7: With `sw[9:8]` = 01, the word is turned left by one place: `segLeft` shows `sw[3:2]`, `segMid` shows `sw[1:0]` and `segRight` shows `sw[5:4]`.
- R8: With `sw[9:8]` = 10, the word is turned left by two places: `segLeft` shows `sw[1:0]`, `segMid` shows `sw[5:4]` and `segRight` shows `sw[3:2]`.
- R9: With `sw[9:8]` = 11, the display is the same as with 00, which is the unturned word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sw | input | 10 | [9:8] rotation select; [5:4], [3:2], [1:0] the first, second and third character codes |
| ledr | output | 10 | Direct copy of `sw` |
| segLeft | output | 7 | Leftmost digit, active low, bit 0 = a |
| segMid | output | 7 | Middle digit, active low, bit 0 = a |
| segRight | output | 7 | Rightmost digit, active low, bit 0 = a |

## Verification
The bench applies all 64 code words under each of the four select values. This catches a multiplexer that turns the word the wrong way. Such a design would show E,1,d where 1,d,E belongs, and the reverse. It also catches select 11 treated as a third step instead of a copy of 00; that design would show a turned word or a blank. Words with repeated letters and all-blank words are in the sweep. They expose a decoder with a swapped segment order or wrong polarity, since its pattern would differ from the expected one even when the position is right. The sweep also compares every LED bit, so a swapped or inverted LED line shows up.

// File: rtl/rotword_pkg.sv
package rotword_pkg;

  typedef enum logic [1:0] {
    CH_D     = 2'b00,
    CH_E     = 2'b01,
    CH_DIGIT = 2'b10,
    CH_BLANK = 2'b11
  } charCode_t;

  // one-hot rotation strobes from control to datapath
  typedef struct packed {
    logic keep;
    logic shift1;
    logic shift2;
  } rotStrobe_t;

  localparam logic [6:0] SEG_D     = 7'h21;
  localparam logic [6:0] SEG_E     = 7'h06;
  localparam logic [6:0] SEG_BLANK = 7'h7F;

endpackage

// File: rtl/rotword_ctrl.sv
module rotword_ctrl
  import rotword_pkg::*;
(
  input  logic [1:0] sel,
  output rotStrobe_t strobes
);

  always_comb begin
    strobes = '0;
    unique case (sel)
      2'b01:   strobes.shift1 = 1'b1;
      2'b10:   strobes.shift2 = 1'b1;
      default: strobes.keep   = 1'b1;   // 00 and 11 show the word as loaded
    endcase
  end

endmodule

// File: rtl/rotword_mux3.sv
module rotword_mux3
  import rotword_pkg::*;
#(
  parameter int CODE_W = 2
) (
  input  logic [CODE_W-1:0] inA,
  input  logic [CODE_W-1:0] inB,
  input  logic [CODE_W-1:0] inC,
  input  rotStrobe_t        strobes,
  output logic [CODE_W-1:0] picked
);

  always_comb begin
    if (strobes.keep)        picked = inA;
    else if (strobes.shift1) picked = inB;
    else                     picked = inC;
  end

endmodule

// File: rtl/rotword_segdec.sv
module rotword_segdec
  import rotword_pkg::*;
#(
  parameter int DIGIT_VAL = 1
) (
  input  logic [1:0] code,
  output logic [6:0] segN
);

  localparam logic [6:0] SEG_DIGIT = (DIGIT_VAL == 0) ? 7'h40 :
                                     (DIGIT_VAL == 2) ? 7'h24 : 7'h79;

  always_comb begin
    unique case (charCode_t'(code))
      CH_D:     segN = SEG_D;
      CH_E:     segN = SEG_E;
      CH_DIGIT: segN = SEG_DIGIT;
      default:  segN = SEG_BLANK;
    endcase
  end

endmodule

// File: rtl/rotword_datapath.sv
module rotword_datapath
  import rotword_pkg::*;
#(
  parameter int NUM_POS   = 3,
  parameter int CODE_W    = 2,
  parameter int SEG_W     = 7,
  parameter int DIGIT_VAL = 1
) (
  input  logic [NUM_POS*CODE_W-1:0] codes,
  input  rotStrobe_t                strobes,
  output logic [NUM_POS*SEG_W-1:0]  segs
);

  // character i (0 = leftmost) sits at the high end of codes
  logic [CODE_W-1:0] charAt [NUM_POS];

  for (genvar i = 0; i < NUM_POS; i++) begin : g_split
    assign charAt[i] = codes[(NUM_POS-1-i)*CODE_W +: CODE_W];
  end

  for (genvar p = 0; p < NUM_POS; p++) begin : g_pos
    localparam int IDX0 = p;
    localparam int IDX1 = (p + 1) % NUM_POS;
    localparam int IDX2 = (p + 2) % NUM_POS;

    logic [CODE_W-1:0] pickedCode;

    rotword_mux3 #(.CODE_W(CODE_W)) u_mux (
      .inA     (charAt[IDX0]),
      .inB     (charAt[IDX1]),
      .inC     (charAt[IDX2]),
      .strobes (strobes),
      .picked  (pickedCode)
    );

    rotword_segdec #(.DIGIT_VAL(DIGIT_VAL)) u_dec (
      .code (pickedCode),
      .segN (segs[p*SEG_W +: SEG_W])
    );
  end

endmodule

// File: rtl/rotword_display.sv
module rotword_display
  import rotword_pkg::*;
#(
  parameter int DIGIT_VAL = 1
) (
  input  logic [9:0] sw,
  output logic [9:0] ledr,
  output logic [6:0] segLeft,
  output logic [6:0] segMid,
  output logic [6:0] segRight
);

  localparam int NUM_POS = 3;
  localparam int CODE_W  = 2;
  localparam int SEG_W   = 7;

  rotStrobe_t               strobes;
  logic [NUM_POS*SEG_W-1:0] segs;

  assign ledr = sw;

  rotword_ctrl u_ctrl (
    .sel     (sw[9:8]),
    .strobes (strobes)
  );

  rotword_datapath #(
    .NUM_POS   (NUM_POS),
    .CODE_W    (CODE_W),
    .SEG_W     (SEG_W),
    .DIGIT_VAL (DIGIT_VAL)
  ) u_dp (
    .codes   (sw[NUM_POS*CODE_W-1:0]),
    .strobes (strobes),
    .segs    (segs)
  );

  assign segLeft  = segs[0*SEG_W +: SEG_W];
  assign segMid   = segs[1*SEG_W +: SEG_W];
  assign segRight = segs[2*SEG_W +: SEG_W];

endmodule

// File: rtl/rotword_checker.sv
module rotword_checker (
  input logic [9:0] sw,
  input logic [9:0] ledr,
  input logic [6:0] segLeft,
  input logic [6:0] segMid,
  input logic [6:0] segRight
);

  function automatic logic isLegal(input logic [6:0] s);
    return (s == 7'h21) || (s == 7'h06) || (s == 7'h40) ||
           (s == 7'h79) || (s == 7'h24) || (s == 7'h7F);
  endfunction

  logic [1:0] blankCodes, blankSegs;

  always_comb begin
    blankCodes = 2'(sw[5:4] == 2'b11) + 2'(sw[3:2] == 2'b11) + 2'(sw[1:0] == 2'b11);
    blankSegs  = 2'(segLeft == 7'h7F) + 2'(segMid == 7'h7F) + 2'(segRight == 7'h7F);

    p_led_copy_r1: assert (ledr == sw);
    // R2, R3, R4, R5: only legal patterns appear
    p_legal_pattern_r2: assert (isLegal(segLeft) && isLegal(segMid) && isLegal(segRight));
    p_blank_count_r5: assert (blankCodes == blankSegs);
    if (sw[5:4] == sw[3:2] && sw[3:2] == sw[1:0])
      p_same_word_r6: assert (segLeft == segMid && segMid == segRight);
    if (sw[9:8] == 2'b00 || sw[9:8] == 2'b11)
      p_left_unturned_r9: assert ((segLeft == 7'h7F) == (sw[5:4] == 2'b11));
    if (sw[9:8] == 2'b01)
      p_left_turn1_r7: assert ((segLeft == 7'h7F) == (sw[3:2] == 2'b11));
    if (sw[9:8] == 2'b10)
      p_left_turn2_r8: assert ((segLeft == 7'h7F) == (sw[1:0] == 2'b11));
  end

endmodule

bind rotword_display rotword_checker u_chk (
  .sw       (sw),
  .ledr     (ledr),
  .segLeft  (segLeft),
  .segMid   (segMid),
  .segRight (segRight)
);

// File: tb/rotword_display_bench.sv
`timescale 1ns/1ps
module rotword_display_bench;

  typedef struct {
    logic [9:0] sw;
    logic [9:0] led;
    logic [6:0] seg [3];
    logic [1:0] code [3];
  } expItem_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [9:0] sw = '0;
  logic [9:0] ledr;
  logic [6:0] segLeft, segMid, segRight;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit driveDone = 0;
  expItem_t q[$];

  always #5 clk = ~clk;

  rotword_display u_rotword_display (
    .sw(sw), .ledr(ledr), .segLeft(segLeft), .segMid(segMid), .segRight(segRight)
  );

  function automatic logic [6:0] refSeg(input logic [1:0] c);
    case (c)
      2'b00:   return 7'h21;  // R2
      2'b01:   return 7'h06;  // R3
      2'b10:   return 7'h79;  // R4 (digit 1)
      default: return 7'h7F;  // R5
    endcase
  endfunction

  function automatic string codeTag(input logic [1:0] c);
    case (c)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic string selTag(input logic [1:0] s);
    case (s)
      2'b00:   return "R6";
      2'b01:   return "R7";
      2'b10:   return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic drive(input logic [9:0] v);
    expItem_t it;
    logic [1:0] ch [3];
    int k;
    @(posedge clk);
    #1 sw = v;
    ch[0] = v[5:4]; ch[1] = v[3:2]; ch[2] = v[1:0];
    k = (v[9:8] == 2'b01) ? 1 : (v[9:8] == 2'b10) ? 2 : 0;
    it.sw  = v;
    it.led = v;
    for (int p = 0; p < 3; p++) begin
      it.code[p] = ch[(p + k) % 3];
      it.seg[p]  = refSeg(it.code[p]);
    end
    q.push_back(it);
  endtask

  task automatic check(input bit ok, input string req, input logic [9:0] act,
                       input logic [9:0] exp, input logic [9:0] stim);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s sw=%b actual=%h expected=%h", req, stim, act, exp);
    end
  endtask

  // monitor: pops one expected item per cycle, samples on the falling edge
  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      expItem_t it;
      logic [6:0] act [3];
      it = q.pop_front();
      act[0] = segLeft; act[1] = segMid; act[2] = segRight;
      check(ledr == it.led, "R1", ledr, it.led, it.sw);
      for (int p = 0; p < 3; p++)
        check(act[p] == it.seg[p], {selTag(it.sw[9:8]), "/", codeTag(it.code[p])},
              {3'b0, act[p]}, {3'b0, it.seg[p]}, it.sw);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // reset state: all-zero switches give ddd and dark LEDs (R1, R2, R6)
    drive(10'b0);
    // explicit word dE1 under every select (R6, R7, R8, R9)
    for (int s = 0; s < 4; s++) drive({2'(s), 2'b00, 6'b00_01_10});
    // full sweep of every word under every select, upper LED bits varied
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 64; c++)
        drive({2'(s), 2'(c[1:0] ^ 2'(s)), 6'(c)});
    driveDone = 1;
    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule